// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits on a host I/O port bus in front of a 16-byte station address PROM. It also passes register traffic through to the rest of a network controller. Each host request carries an offset, a size code, a direction and write data. The block sorts the request into one of three classes: a legal PROM access, a forwarded register access, or a rejected access.

A legal PROM access is split into byte operations or built up from them, lowest address in the lowest byte. Which PROM sizes are legal depends on an external doubleword-mode input. PROM writes take effect only while an external write-enable input is high. Requests at offsets of 16 and above go out on a simple register port, which answers in the same cycle. Read results are registered and come back one cycle after the request, together with a one-cycle valid pulse.

Top module: `prom_io_decoder`

## Requirements
- R1: Offsets below 16 (PROM_DEPTH) select the PROM, and the PROM byte index is the low four offset bits. Offsets of 16 and above never touch the PROM.
- R2: With `dw_mode` low, a 1-byte PROM access (size code 0) is legal at any offset, and a 2-byte access (size code 1) is legal only at an even offset. A 4-byte access (size code 2) is rejected.
- R3: With `dw_mode` high, the only legal PROM access is a 4-byte access (size code 2) at an offset whose two low bits are zero. Every other PROM access is rejected.
- R4: Multi-byte PROM data is little-endian: the byte at offset A sits in bits 7:0, A+1 in 15:8, A+2 in 23:16 and A+3 in 31:24. Bits above the access size read as zero.
- R5: A legal PROM write changes the PROM only while `prom_we_en` is high. Otherwise the contents stay unchanged and no error is raised.
- R6: A rejected read returns all ones across the requested size: 0x000000FF for size code 0, 0x0000FFFF for size code 1, 0xFFFFFFFF for size code 2. The reserved size code 3 is always rejected and reads 0xFFFFFFFF.
- R7: At offsets of 16 and above, 2-byte and 4-byte accesses raise `reg_req` in the request cycle. In that cycle `reg_write` follows the direction, `reg_dword` is high only for 4 bytes, and `reg_addr` and `reg_wdata` carry the request. The read result is `reg_rdata`, with its upper 16 bits forced to zero for 2-byte reads.
- R8: A 1-byte access at offset 16 or above raises no `reg_req`, and a 1-byte read there returns 0x000000FF.
- R9: A rejected write (bad alignment or bad size for the mode) leaves every PROM byte unchanged.
- R10: Reset clears all PROM bytes to zero and holds `rd_valid` low.
- R11: Every read request produces exactly one `rd_valid` pulse, in the cycle after the request, with `rd_data` valid at the same time. Write requests produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wdata | input | 32 | Write data, little-endian lanes |
| dw_mode | input | 1 | Doubleword I/O mode select |
| prom_we_en | input | 1 | PROM write enable |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 32 | Registered read result |
| reg_req | output | 1 | Forwarded register access strobe |
| reg_write | output | 1 | Forwarded access direction |
| reg_dword | output | 1 | Forwarded access is 4 bytes (else 2) |
| reg_addr | output | ADDR_W | Forwarded offset |
| reg_wdata | output | 32 | Forwarded write data |
| reg_rdata | input | 32 | Register port read data, same cycle |

## Verification
The PROM is first filled with byte writes of distinct values. Word reads and doubleword reads then show whether lanes are ordered correctly, since a swapped or shifted byte shows up as a different value. Each size is tried at even, odd and unaligned offsets in both modes, so the legality table is probed cell by cell. Each rejected read is compared against the all-ones width for its size, and each rejected or disabled write is followed by a byte read of the target location. Forwarded traffic is run against an offset-dependent register stub, which separates a correct forward from a rejection or a PROM hit at the 15/16 boundary.

// File: rtl/prom_io_pkg.sv
package prom_io_pkg;

   typedef enum logic [1:0] {
      ACC_REJECT = 2'd0,
      ACC_PROM   = 2'd1,
      ACC_FWD    = 2'd2
   } acc_kind_e;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_WORD  = 2'd1;
   localparam logic [1:0] SZ_DWORD = 2'd2;

   // number of bytes moved for a size code (reserved code treated as 4)
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_WORD: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

   // all-ones pattern across the requested width
   function automatic logic [31:0] ones_mask(input logic [1:0] code);
      case (code)
         SZ_BYTE: ones_mask = 32'h0000_00FF;
         SZ_WORD: ones_mask = 32'h0000_FFFF;
         default: ones_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/prom_io_decode.sv
module prom_io_decode
   import prom_io_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PROM_DEPTH = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              dw_mode,
   output acc_kind_e         kind
);
   localparam int IDX_W = $clog2(PROM_DEPTH);

   logic in_prom;
   logic even_ok;
   logic quad_ok;

   assign in_prom = ({{(32-ADDR_W){1'b0}}, addr} < 32'(PROM_DEPTH));
   assign even_ok = (addr[0] == 1'b0);
   assign quad_ok = (addr[1:0] == 2'b00);

   always_comb begin
      kind = ACC_REJECT;
      if (in_prom) begin
         if (dw_mode) begin
            if (size == SZ_DWORD && quad_ok) kind = ACC_PROM;
         end else begin
            if (size == SZ_BYTE)                kind = ACC_PROM;
            else if (size == SZ_WORD && even_ok) kind = ACC_PROM;
         end
      end else begin
         if (size == SZ_WORD || size == SZ_DWORD) kind = ACC_FWD;
      end
   end

   if (IDX_W < 2) begin : g_bad_idx
      $error("prom_io_decode: PROM_DEPTH must be at least 4");
   end

endmodule

// File: rtl/prom_io_lanes.sv
module prom_io_lanes #(
   parameter int PROM_DEPTH = 16,
   parameter int LANES      = 4,
   localparam int IDX_W     = $clog2(PROM_DEPTH)
) (
   input  logic [IDX_W-1:0]            base,
   input  logic [2:0]                  nbytes,
   input  logic [LANES*8-1:0]          wdata,
   input  logic                        wr_en,
   input  logic [PROM_DEPTH-1:0][7:0]  rbytes,
   output logic [PROM_DEPTH-1:0]       we_bytes,
   output logic [PROM_DEPTH-1:0][7:0]  wbytes,
   output logic [LANES*8-1:0]          rdata
);
   localparam int LSEL_W = $clog2(LANES);

   // write side: each PROM byte finds its lane from its distance to base
   for (genvar j = 0; j < PROM_DEPTH; j++) begin : g_wr
      logic [IDX_W-1:0] ofs;
      assign ofs         = IDX_W'(j) - base;
      assign we_bytes[j] = wr_en && (32'(ofs) < 32'(nbytes));
      assign wbytes[j]   = wdata[32'(ofs[LSEL_W-1:0])*8 +: 8];
   end

   // read side: each lane picks the PROM byte at base + lane
   for (genvar k = 0; k < LANES; k++) begin : g_rd
      logic [IDX_W-1:0] idx;
      assign idx = base + IDX_W'(k);
      assign rdata[k*8 +: 8] = (32'(k) < 32'(nbytes)) ? rbytes[idx] : 8'h00;
   end

endmodule

// File: rtl/prom_io_store.sv
module prom_io_store #(
   parameter int PROM_DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [PROM_DEPTH-1:0]      we_bytes,
   input  logic [PROM_DEPTH-1:0][7:0] wbytes,
   output logic [PROM_DEPTH-1:0][7:0] rbytes
);
   for (genvar j = 0; j < PROM_DEPTH; j++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           rbytes[j] <= 8'h00;
         else if (we_bytes[j]) rbytes[j] <= wbytes[j];
      end
   end
endmodule

// File: rtl/prom_io_decoder.sv
module prom_io_decoder
   import prom_io_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PROM_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   input  logic              dw_mode,
   input  logic              prom_we_en,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              reg_req,
   output logic              reg_write,
   output logic              reg_dword,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [31:0]       reg_wdata,
   input  logic [31:0]       reg_rdata
);
   localparam int IDX_W = $clog2(PROM_DEPTH);
   localparam int LANES = 4;

   if ((PROM_DEPTH & (PROM_DEPTH - 1)) != 0 || PROM_DEPTH < LANES) begin : g_bad_depth
      $error("prom_io_decoder: PROM_DEPTH must be a power of two, at least 4");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("prom_io_decoder: ADDR_W must exceed the PROM index width");
   end

   acc_kind_e                  kind;
   logic [PROM_DEPTH-1:0]      we_bytes;
   logic [PROM_DEPTH-1:0][7:0] wbytes;
   logic [PROM_DEPTH-1:0][7:0] rbytes;
   logic [31:0]                prom_rdata;
   logic [31:0]                fwd_rdata;
   logic [31:0]                rd_nxt;
   logic                       prom_wr;
   logic                       is_read;

   prom_io_decode #(.ADDR_W(ADDR_W), .PROM_DEPTH(PROM_DEPTH)) u_decode (
      .addr    (req_addr),
      .size    (req_size),
      .dw_mode (dw_mode),
      .kind    (kind)
   );

   assign prom_wr = req_valid && req_write && prom_we_en && (kind == ACC_PROM);
   assign is_read = req_valid && !req_write;

   prom_io_lanes #(.PROM_DEPTH(PROM_DEPTH), .LANES(LANES)) u_lanes (
      .base     (req_addr[IDX_W-1:0]),
      .nbytes   (size_bytes(req_size)),
      .wdata    (req_wdata),
      .wr_en    (prom_wr),
      .rbytes   (rbytes),
      .we_bytes (we_bytes),
      .wbytes   (wbytes),
      .rdata    (prom_rdata)
   );

   prom_io_store #(.PROM_DEPTH(PROM_DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_bytes (we_bytes),
      .wbytes   (wbytes),
      .rbytes   (rbytes)
   );

   // forwarded register port, combinational in the request cycle
   assign reg_req   = req_valid && (kind == ACC_FWD);
   assign reg_write = req_write;
   assign reg_dword = (req_size == SZ_DWORD);
   assign reg_addr  = req_addr;
   assign reg_wdata = req_wdata;
   assign fwd_rdata = reg_rdata & ones_mask(req_size);

   always_comb begin
      case (kind)
         ACC_PROM: rd_nxt = prom_rdata;
         ACC_FWD:  rd_nxt = fwd_rdata;
         default:  rd_nxt = ones_mask(req_size);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 32'h0;
      end else begin
         rd_valid <= is_read;
         if (is_read) rd_data <= rd_nxt;
      end
   end

endmodule

// File: rtl/prom_io_decoder_chk.sv
module prom_io_decoder_chk #(
   parameter int ADDR_W     = 8,
   parameter int PROM_DEPTH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              dw_mode,
   input logic              rd_valid,
   input logic [31:0]       rd_data,
   input logic              reg_req
);
   logic high_range;
   assign high_range = (32'(req_addr) >= 32'(PROM_DEPTH));

   // R7
   fwd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |-> (high_range && (req_size == 2'd1 || req_size == 2'd2)));

   // R11
   rdv_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write));

   // R6
   reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd3) |=> (rd_data == 32'hFFFF_FFFF));

   // R8
   high_byte_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 2'd0 && high_range)
      |=> (rd_data == 32'h0000_00FF));

   // R3
   dw_byte_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && dw_mode && req_size == 2'd0)
      |=> (rd_data == 32'h0000_00FF));

   // R11
   no_pulse_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rd_valid);

endmodule

bind prom_io_decoder prom_io_decoder_chk #(.ADDR_W(ADDR_W), .PROM_DEPTH(PROM_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_size  (req_size),
   .dw_mode   (dw_mode),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .reg_req   (reg_req)
);

// File: tb/prom_io_decoder_tb.sv
module prom_io_decoder_tb;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = 2'd0;
   logic [31:0]   req_wdata = '0;
   logic          dw_mode = 1'b0;
   logic          prom_we_en = 1'b0;
   logic          rd_valid;
   logic [31:0]   rd_data;
   logic          reg_req, reg_write, reg_dword;
   logic [AW-1:0] reg_addr;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;

   int errors = 0;
   int checks = 0;
   byte unsigned model [16];

   always #4 clk = ~clk;

   // register port stub: data depends on the offset
   assign reg_rdata = {8'hC3, reg_addr, ~reg_addr, 8'h5A};

   prom_io_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .dw_mode(dw_mode), .prom_we_en(prom_we_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .reg_req(reg_req), .reg_write(reg_write),
      .reg_dword(reg_dword), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int nbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] ones(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   // 0 reject, 1 prom, 2 forward
   function automatic int classify(input int a, input logic [1:0] sz);
      if (a < 16) begin
         if (dw_mode) return (sz == 2'd2 && a % 4 == 0) ? 1 : 0;
         if (sz == 2'd0) return 1;
         if (sz == 2'd1 && a % 2 == 0) return 1;
         return 0;
      end
      return (sz == 2'd1 || sz == 2'd2) ? 2 : 0;
   endfunction

   task automatic access(input bit wr, input int a, input logic [1:0] sz,
                         input logic [31:0] wd, input string req);
      int cls;
      logic [31:0] exp;
      logic [31:0] stub;
      cls = classify(a, sz);
      exp = ones(sz);
      if (cls == 1) begin
         exp = 0;
         for (int k = 0; k < nbytes(sz); k++) exp |= 32'(model[(a + k) % 16]) << (8 * k);
      end
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_size = sz; req_wdata = wd;
      #1;
      check({req, " reg_req"}, 32'(reg_req), 32'(cls == 2));
      if (cls == 2) begin
         stub = {8'hC3, 8'(a), ~8'(a), 8'h5A};
         exp  = stub & ones(sz);
         check({req, " reg_dword"}, 32'(reg_dword), 32'(sz == 2'd2));
         check({req, " reg_write"}, 32'(reg_write), 32'(wr));
         check({req, " reg_addr"}, 32'(reg_addr), 32'(a));
         if (wr) check({req, " reg_wdata"}, reg_wdata, wd);
      end
      if (wr && cls == 1 && prom_we_en)
         for (int k = 0; k < nbytes(sz); k++) model[(a + k) % 16] = wd[8*k +: 8];
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " rd_valid"}, 32'(rd_valid), 32'(!wr));
      if (!wr) check({req, " rd_data"}, rd_data, exp);
      #1;
      // pulse lasts one cycle only
      @(negedge clk);
      check({req, " rd_valid drop"}, 32'(rd_valid), 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 rd_valid in reset", 32'(rd_valid), 32'h0);
      check("R10 rd_data in reset", rd_data, 32'h0);
      rst_n = 1'b1;
      access(0, 0, 2'd0, 0, "R10 prom byte0 cleared");
      access(0, 14, 2'd1, 0, "R10 prom word14 cleared");
      // R5: writes dropped when disabled
      access(1, 3, 2'd0, 32'h55, "R5 write disabled");
      access(0, 3, 2'd0, 0, "R5 byte3 unchanged");
      // fill PROM with byte writes (R2, R1)
      prom_we_en = 1'b1;
      for (int i = 0; i < 16; i++) access(1, i, 2'd0, 32'(8'h10 + i), "R2 byte write");
      access(0, 15, 2'd0, 0, "R1 last prom byte");
      access(0, 4, 2'd1, 0, "R4 R2 even word read");
      access(0, 5, 2'd1, 0, "R2 R6 odd word read");
      access(0, 0, 2'd2, 0, "R2 R6 dword in word mode");
      access(1, 7, 2'd1, 32'hAAAA, "R9 odd word write");
      access(0, 7, 2'd0, 0, "R9 byte7 after odd write");
      access(0, 8, 2'd0, 0, "R9 byte8 after odd write");
      access(1, 10, 2'd1, 32'hBEEF, "R4 even word write");
      access(0, 10, 2'd0, 0, "R4 low byte of word");
      access(0, 11, 2'd0, 0, "R4 high byte of word");
      access(0, 3, 2'd3, 0, "R6 reserved size");
      // doubleword mode (R3)
      dw_mode = 1'b1;
      access(0, 8, 2'd2, 0, "R3 R4 aligned dword");
      access(0, 2, 2'd2, 0, "R3 unaligned dword");
      access(0, 1, 2'd0, 0, "R3 byte in dw mode");
      access(0, 4, 2'd1, 0, "R3 word in dw mode");
      access(1, 12, 2'd2, 32'hDEAD_BEEF, "R3 dword write");
      access(1, 6, 2'd2, 32'h1234_5678, "R9 unaligned dword write");
      access(1, 0, 2'd0, 32'h77, "R9 byte write in dw mode");
      prom_we_en = 1'b0;
      access(1, 4, 2'd2, 32'hCAFE_F00D, "R5 dword write disabled");
      access(0, 4, 2'd2, 0, "R5 dword unchanged");
      access(0, 12, 2'd2, 0, "R4 dword readback");
      dw_mode = 1'b0;
      access(0, 0, 2'd0, 0, "R9 byte0 unchanged");
      access(0, 6, 2'd1, 0, "R9 word6 unchanged");
      access(0, 15, 2'd0, 0, "R4 byte15");
      // forwarded range (R7, R8)
      access(1, 16, 2'd1, 32'h0000_9ABC, "R7 word write at 16");
      access(0, 20, 2'd2, 0, "R7 dword read");
      access(0, 34, 2'd1, 0, "R7 word read masked");
      access(1, 40, 2'd2, 32'h0BAD_CAFE, "R7 dword write");
      access(0, 16, 2'd0, 0, "R8 byte read high");
      access(1, 24, 2'd0, 32'h11, "R8 byte write high");
      access(0, 17, 2'd3, 0, "R6 reserved high");
      dw_mode = 1'b1;
      access(0, 18, 2'd1, 0, "R7 forward in dw mode");
      access(0, 0, 2'd0, 0, "R1 R3 byte at 0 dw mode");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule